// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block sits beside a software- or byte-engine-driven I2C master and watches the shared SCL and SDA wires. It recognises Start and Stop conditions, keeps a pair of status bits that flip against each other, and tells the local master when it may try to take the bus. It also keeps an interrupt flag that is raised by bus conditions and by completed byte transfers.

For multi-master use the block also checks arbitration for the local open-drain driver. The driver only ever pulls a line low, so a '1' means releasing the line to the pull-ups. While the local side is sending a bit and releasing SDA, the block compares that intent with the SDA level it actually samples on each SCL rising edge. A mismatch means another master has won. Both local line pulls are then dropped, and the loss is recorded as having happened during either the address byte or a later data byte.

The block tracks the address phase itself. The phase begins at a Start and ends after the ninth SCL clock of the first byte.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, and whenever `enable_i` is low, both `start_seen_o` and `stop_seen_o` read 0.
- R2: SDA falling while SCL is high (a Start) sets `start_seen_o` to 1 and clears `stop_seen_o`.
- R3: SDA rising while SCL is high (a Stop) sets `stop_seen_o` to 1 and clears `start_seen_o`.
- R4: `bus_free_o` is 1 when `stop_seen_o` is 1, or when both status bits are 0. It is 0 only after a Start with no Stop since.
- R5: An SDA change while SCL is low, and an SDA level held steady, change neither status bit nor the interrupt flag.
- R6: `irq_flag_o` is set by a Start, by a Stop, or by a `byte_done_i` pulse. It stays set until `irq_clr_i` is high on a clock edge, and a new set event on that same edge wins over the clear.
- R7: `irq_o` equals `irq_flag_o` gated by `irq_en_i`. If the flag is cleared and the interrupt is enabled while the bus is busy, `irq_o` rises at the next Stop.
- R8: On an SCL rising edge with `tx_active_i` = 1 and `sda_drive_low_i` = 0, an SDA sample of 0 records an arbitration loss. When `sda_drive_low_i` = 1, or SDA is sampled high, no loss is recorded.
- R9: A loss seen on any of the first nine SCL rising edges after a Start sets `arb_lost_addr_o`. A loss on any later rising edge sets `arb_lost_data_o`. Either flag stays set until `arb_clr_i` is high on a clock edge.
- R10: While either loss flag is set, `sda_pull_o` and `scl_pull_o` are both 0. Otherwise they follow `sda_drive_low_i` and `scl_drive_low_i`.
- R11: While `enable_i` is low, bus conditions, byte-done pulses and SCL edges set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Monitor enable; low clears the status bits and the address phase |
| scl_i | input | 1 | SCL wire level (asynchronous) |
| sda_i | input | 1 | SDA wire level (asynchronous) |
| sda_drive_low_i | input | 1 | Local driver intends SDA low (1) or released (0) |
| scl_drive_low_i | input | 1 | Local driver intends SCL low |
| tx_active_i | input | 1 | Local master is sending the current bit |
| byte_done_i | input | 1 | One-cycle pulse: a byte was sent or received |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| arb_clr_i | input | 1 | Clear both arbitration-loss flags |
| start_seen_o | output | 1 | Start status bit |
| stop_seen_o | output | 1 | Stop status bit |
| bus_free_o | output | 1 | Bus may be taken by a new master |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Enabled interrupt request |
| arb_lost_addr_o | output | 1 | Arbitration lost during the address byte |
| arb_lost_data_o | output | 1 | Arbitration lost during a data byte |
| addr_phase_o | output | 1 | Address byte in progress |
| sda_pull_o | output | 1 | Pull SDA low (open-drain enable) |
| scl_pull_o | output | 1 | Pull SCL low (open-drain enable) |

## Verification
Every output reacts three clock edges after a line change: two synchronizer stages and one status register. A wrong status or phase register therefore shows at the ports within four cycles of the stimulus. A stuck or mis-set Start/Stop bit shows as a wrong `bus_free_o` and a wrong interrupt flag on the very transition that should have moved it. A phase counter that is off by one shows as a loss recorded in the wrong flag when the contested bit is the ninth or the tenth. The bench reaches that case by sweeping the losing bit across two whole bytes.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned SYNC_STAGES   = 2;
  localparam int unsigned BITS_PER_BYTE = 8;

  typedef struct packed {
    logic scl;
    logic sda;
  } i2c_lines_t;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_det_o,
  output logic stop_det_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic s_o,
  output logic p_o
);
  logic scl_q, sda_q, s_q, p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // conditions judged only with SCL high on both samples
  assign start_det_o = enable_i & scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_det_o  = enable_i & scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o  = enable_i & scl_s_i & ~scl_q;
  assign scl_fall_o  = enable_i & ~scl_s_i & scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= 1'b0;
      p_q <= 1'b0;
    end else if (!enable_i) begin
      s_q <= 1'b0;
      p_q <= 1'b0;
    end else if (start_det_o) begin
      s_q <= 1'b1;
      p_q <= 1'b0;
    end else if (stop_det_o) begin
      s_q <= 1'b0;
      p_q <= 1'b1;
    end
  end

  assign s_o = s_q;
  assign p_o = p_q;

  // R1
  s_p_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(s_q && p_q));
  // R2
  start_sets_s_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_o |=> (s_q && !p_q));
  // R3
  stop_sets_p_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_o |=> (p_q && !s_q));
endmodule

// File: rtl/i2c_mon_arb.sv
module i2c_mon_arb #(
  parameter int unsigned BITS_PER_BYTE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic sda_s_i,
  input  logic tx_active_i,
  input  logic sda_drive_low_i,
  input  logic arb_clr_i,
  output logic lost_addr_o,
  output logic lost_data_o,
  output logic addr_phase_o
);
  localparam int unsigned ADDR_CLKS = BITS_PER_BYTE + 1;
  localparam int unsigned CW        = $clog2(ADDR_CLKS + 1);
  localparam logic [CW-1:0] LAST    = CW'(ADDR_CLKS);

  logic [CW-1:0] clk_cnt_q;
  logic          addr_q, lost_addr_q, lost_data_q, mismatch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= 1'b0;
      clk_cnt_q <= '0;
    end else if (!enable_i || stop_det_i) begin
      addr_q    <= 1'b0;
      clk_cnt_q <= '0;
    end else if (start_det_i) begin
      addr_q    <= 1'b1;
      clk_cnt_q <= '0;
    end else if (addr_q) begin
      if (scl_rise_i && clk_cnt_q != LAST) clk_cnt_q <= clk_cnt_q + 1'b1;
      if (scl_fall_i && clk_cnt_q == LAST) addr_q <= 1'b0;
    end
  end

  // released SDA sampled low on an SCL rising edge
  assign mismatch = scl_rise_i & tx_active_i & ~sda_drive_low_i & ~sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_addr_q <= 1'b0;
      lost_data_q <= 1'b0;
    end else begin
      if (mismatch && addr_q)       lost_addr_q <= 1'b1;
      else if (arb_clr_i)           lost_addr_q <= 1'b0;
      if (mismatch && !addr_q)      lost_data_q <= 1'b1;
      else if (arb_clr_i)           lost_data_q <= 1'b0;
    end
  end

  assign lost_addr_o  = lost_addr_q;
  assign lost_data_o  = lost_data_q;
  assign addr_phase_o = addr_q;

  // R8
  loss_only_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lost_addr_q && !lost_data_q && !scl_rise_i) |=> (!lost_addr_q && !lost_data_q));
  // R9
  loss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_addr_q && !arb_clr_i) |=> lost_addr_q);
  // R9
  phase_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_cnt_q <= LAST);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_STAGES,
  parameter int unsigned BYTE_BITS  = BITS_PER_BYTE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sda_drive_low_i,
  input  logic scl_drive_low_i,
  input  logic tx_active_i,
  input  logic byte_done_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  input  logic arb_clr_i,
  output logic start_seen_o,
  output logic stop_seen_o,
  output logic bus_free_o,
  output logic irq_flag_o,
  output logic irq_o,
  output logic arb_lost_addr_o,
  output logic arb_lost_data_o,
  output logic addr_phase_o,
  output logic sda_pull_o,
  output logic scl_pull_o
);
  i2c_lines_t raw, synced;
  logic start_det, stop_det, scl_rise, scl_fall, s_bit, p_bit;
  logic irq_q, lost_any;

  assign raw.scl = scl_i;
  assign raw.sda = sda_i;

  for (genvar g = 0; g < $bits(i2c_lines_t); g++) begin : g_sync
    i2c_mon_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (synced[g])
    );
  end

  i2c_mon_cond i_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .scl_s_i    (synced.scl),
    .sda_s_i    (synced.sda),
    .start_det_o(start_det),
    .stop_det_o (stop_det),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .s_o        (s_bit),
    .p_o        (p_bit)
  );

  i2c_mon_arb #(.BITS_PER_BYTE(BYTE_BITS)) i_arb (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .enable_i       (enable_i),
    .start_det_i    (start_det),
    .stop_det_i     (stop_det),
    .scl_rise_i     (scl_rise),
    .scl_fall_i     (scl_fall),
    .sda_s_i        (synced.sda),
    .tx_active_i    (tx_active_i),
    .sda_drive_low_i(sda_drive_low_i),
    .arb_clr_i      (arb_clr_i),
    .lost_addr_o    (arb_lost_addr_o),
    .lost_data_o    (arb_lost_data_o),
    .addr_phase_o   (addr_phase_o)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                irq_q <= 1'b0;
    else if (start_det || stop_det || (enable_i && byte_done_i)) irq_q <= 1'b1;
    else if (irq_clr_i)                                         irq_q <= 1'b0;
  end

  assign lost_any     = arb_lost_addr_o | arb_lost_data_o;
  assign start_seen_o = s_bit;
  assign stop_seen_o  = p_bit;
  assign bus_free_o   = p_bit | ~s_bit;
  assign irq_flag_o   = irq_q;
  assign irq_o        = irq_q & irq_en_i;
  assign sda_pull_o   = sda_drive_low_i & ~lost_any;
  assign scl_pull_o   = scl_drive_low_i & ~lost_any;

  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  // R10
  release_on_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_addr_o || arb_lost_data_o) |-> (!sda_pull_o && !scl_pull_o));
  // R4
  busy_only_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_free_o |-> start_seen_o);
endmodule

// File: tb/test_i2c_bus_monitor.sv
module test_i2c_bus_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, scl = 1'b1, sda = 1'b1, sda_low = 1'b0, scl_low = 1'b0;
  logic tx_act = 1'b0, bdone = 1'b0, irq_en = 1'b0, irq_clr = 1'b0, arb_clr = 1'b0;
  logic s_o, p_o, free_o, flag_o, irq_o, la_o, ld_o, ap_o, sdap_o, sclp_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  i2c_bus_monitor i_i2c_bus_monitor (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .scl_i(scl), .sda_i(sda),
    .sda_drive_low_i(sda_low), .scl_drive_low_i(scl_low), .tx_active_i(tx_act),
    .byte_done_i(bdone), .irq_en_i(irq_en), .irq_clr_i(irq_clr), .arb_clr_i(arb_clr),
    .start_seen_o(s_o), .stop_seen_o(p_o), .bus_free_o(free_o), .irq_flag_o(flag_o),
    .irq_o(irq_o), .arb_lost_addr_o(la_o), .arb_lost_data_o(ld_o), .addr_phase_o(ap_o),
    .sda_pull_o(sdap_o), .scl_pull_o(sclp_o));

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // change lines, let them pass sync + status register, sample at negedge
  task automatic lines(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic pulse_arb_clr();
    @(negedge clk); arb_clr = 1'b1;
    @(negedge clk); arb_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(s_o, 1'b0, "R1 S after reset");
    chk(p_o, 1'b0, "R1 P after reset");
    chk(free_o, 1'b1, "R4 free after reset");
    chk(flag_o, 1'b0, "R6 flag after reset");
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6: sweep SCL level and every SDA transition
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 2; f++)
        for (int t = 0; t < 2; t++) begin
          logic es, ep;
          @(negedge clk); enable = 1'b0;
          lines(1'b0, 1'b1);
          lines(1'b0, f[0]);
          lines(c[0], f[0]);
          @(negedge clk); enable = 1'b1;
          pulse_irq_clr();
          lines(c[0], t[0]);
          es = c[0] & f[0] & ~t[0];
          ep = c[0] & ~f[0] & t[0];
          chk(s_o, es, "R2 S after transition");
          chk(p_o, ep, "R3 P after transition");
          chk(free_o, ep | ~es, "R4 bus free");
          chk(flag_o, es | ep, "R5 R6 flag on condition only");
        end

    // R1 R11: disable clears status, conditions ignored while disabled
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    chk(s_o, 1'b1, "R2 S set before disable");
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    chk(s_o, 1'b0, "R1 S cleared by disable");
    pulse_irq_clr();
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    @(negedge clk); bdone = 1'b1;
    @(negedge clk); bdone = 1'b0;
    chk(s_o, 1'b0, "R11 start ignored when disabled");
    chk(flag_o, 1'b0, "R11 no irq when disabled");
    lines(1'b1, 1'b1);
    chk(p_o, 1'b0, "R11 stop ignored when disabled");
    @(negedge clk); enable = 1'b1;

    // R6 byte_done sets flag, held until clear, set wins
    @(negedge clk); bdone = 1'b1;
    @(negedge clk); bdone = 1'b0;
    chk(flag_o, 1'b1, "R6 byte_done sets flag");
    repeat (5) @(negedge clk);
    chk(flag_o, 1'b1, "R6 flag held");
    @(negedge clk); bdone = 1'b1; irq_clr = 1'b1;
    @(negedge clk); bdone = 1'b0; irq_clr = 1'b0;
    chk(flag_o, 1'b1, "R6 set wins over clear");
    pulse_irq_clr();
    chk(flag_o, 1'b0, "R6 clear");

    // R7 enable while busy, irq at next stop
    lines(1'b1, 1'b0);
    chk(irq_o, 1'b0, "R7 irq masked");
    chk(free_o, 1'b0, "R4 busy after start");
    pulse_irq_clr();
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    chk(irq_o, 1'b0, "R7 no irq while busy");
    lines(1'b1, 1'b1);
    chk(irq_o, 1'b1, "R7 irq at stop");
    @(negedge clk); irq_en = 1'b0;

    // R8 driving low while sampled low is no loss
    tx_act = 1'b1; sda_low = 1'b1; scl_low = 1'b1;
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    chk(la_o | ld_o, 1'b0, "R8 no loss when driving low");
    chk(sdap_o, 1'b1, "R10 pulls follow drive");
    chk(sclp_o, 1'b1, "R10 scl pull follows drive");
    lines(1'b1, 1'b1);
    sda_low = 1'b0;

    // R8 R9 R10: sweep the losing bit across two bytes
    for (int k = 0; k < 18; k++) begin
      pulse_arb_clr();
      lines(1'b1, 1'b1);
      lines(1'b1, 1'b0);
      lines(1'b0, 1'b0);
      for (int j = 0; j < k; j++) begin
        lines(1'b0, 1'b1);
        lines(1'b1, 1'b1);
        lines(1'b0, 1'b1);
      end
      chk(la_o | ld_o, 1'b0, "R8 no loss when sampled high");
      lines(1'b0, 1'b0);
      lines(1'b1, 1'b0);
      chk(la_o, (k < 9) ? 1'b1 : 1'b0, "R9 address-phase loss flag");
      chk(ld_o, (k < 9) ? 1'b0 : 1'b1, "R9 data-phase loss flag");
      chk(sclp_o, 1'b0, "R10 scl released on loss");
      lines(1'b1, 1'b1);
      chk(la_o | ld_o, 1'b1, "R9 flag held past stop");
    end
    pulse_arb_clr();
    chk(la_o | ld_o, 1'b0, "R9 flags cleared");
    chk(sclp_o, 1'b1, "R10 scl pull restored");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule